// File: doc/BRIEF.md
# Two-Level Address Translation Walker

The walker turns an I/O virtual address into a physical address by reading two levels of a table that software has built in memory. A client presents a virtual address together with a read/write flag. The walker reads the first-level entry, then the second-level entry, and returns the physical page frame joined to the page offset. It also passes on the page's cache-attribute hints. An absent mapping or a missing permission produces a page fault. A failed table read produces a separate bus-error fault. In both cases the faulting address and the access direction are kept until software acknowledges the fault.

The directory base comes from a control register. It is sampled when a request is accepted. Table reads leave through a request channel with a valid/ready handshake and return on a response channel that carries data and an error flag. Only one walk is in flight at a time. Requests are refused while a walk is running and while a fault is waiting for its acknowledgement.

Top module: `xlat_walker`

## Requirements
- R1: With the default widths, virtual address bits 31:22 select the first-level entry, bits 21:12 select the second-level entry, and bits 11:0 are the byte offset. In general the first-level index is the top L1_IDX_W bits, the second-level index is the next L2_IDX_W bits, and the offset is the low 12 bits.
- R2: The first-level read goes to `{dir_base[31:12], 12'h000} + 4 * first-level index`. The base is taken from dir_base when the request is accepted, and dir_base[11:0] is ignored.
- R3: In a first-level entry, bit 0 is the valid flag and bits 31:12 are the second-level table frame. Bits 11:1 are ignored. The second-level read goes to `{entry[31:12], 12'h000} + 4 * second-level index`.
- R4: In a second-level entry, bit 0 is valid, bit 1 grants reads and bit 2 grants writes. On success rsp_valid is high for exactly one cycle, in the cycle after the second-level response. In that cycle rsp_pa = `{entry[31:12], offset}`.
- R5: rsp_attr equals second-level entry bits 8:3 unchanged. Bit 0 of rsp_attr (entry bit 3) is the override select for bits 5:1. These bits never alter rsp_pa or the fault decision.
- R6: An entry whose valid bit is 0 raises fault_page in the cycle after its response. An invalid first-level entry causes no second-level read. A walk that faults never pulses rsp_valid.
- R7: A read to a page with bit 1 clear, or a write to a page with bit 2 clear, raises fault_page.
- R8: While a fault flag is high, fault_va holds the full virtual address of the failed walk and fault_write holds its write flag. Both stay stable until the fault is cleared.
- R9: A response with mem_rsp_err high raises fault_bus and not fault_page, whatever data it carries. It does so at either level. fault_page and fault_bus are never high together.
- R10: While a fault flag is high, req_ready and mem_req_valid are 0. A fault_done pulse clears both flags, and req_ready is 1 in the next cycle. A fault_done pulse with no fault pending has no effect.
- R11: req_ready is 1 only when no walk is in flight. Once mem_req_valid is high, it stays high with a stable mem_req_addr until mem_req_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_base | input | 32 | First-level table base from the control register |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_va | input | VA_W | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Memory accepts the table read |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Table read data valid |
| mem_rsp_data | input | 32 | Table entry read from memory |
| mem_rsp_err | input | 1 | Table read ended in a bus error |
| rsp_valid | output | 1 | One-cycle pulse: translation done |
| rsp_pa | output | 32 | Physical address |
| rsp_attr | output | 6 | Cache-attribute hints from the page entry |
| fault_page | output | 1 | Page fault pending |
| fault_bus | output | 1 | Bus-error fault pending |
| fault_va | output | VA_W | Virtual address of the failed walk |
| fault_write | output | 1 | Failed walk was a write |
| fault_done | input | 1 | Acknowledge and clear a pending fault |

## Verification
The bench builds the walker with 3-bit first- and second-level indices, which gives an 18-bit virtual address and 64 pages. This size puts every page, in both directions, within one sweep. The sweep reaches invalid entries at both levels, every combination of read and write grant, and the lowest and highest page offsets. Entries are generated arithmetically from their indices, with noise in the ignored bits. Memory handshake delays vary from walk to walk. Directed walks add bus errors at each level, one of them on an entry that is also invalid, and an acknowledge pulse sent with no fault pending.

// File: rtl/walk_pkg.sv
package walk_pkg;
  localparam int ENT_W      = 32;
  localparam int PAGE_SHIFT = 12;
  localparam int FRAME_W    = ENT_W - PAGE_SHIFT;
  localparam int BIT_VALID  = 0;
  localparam int BIT_RD     = 1;
  localparam int BIT_WR     = 2;
  localparam int ATTR_LSB   = 3;
  localparam int ATTR_W     = 6;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_L1_REQ  = 3'd1,
    ST_L1_WAIT = 3'd2,
    ST_L2_REQ  = 3'd3,
    ST_L2_WAIT = 3'd4,
    ST_FAULT   = 3'd5
  } walk_state_e;
endpackage

// File: rtl/walk_fetch_addr.sv
module walk_fetch_addr
  import walk_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic [FRAME_W-1:0] tbl_frame,
  input  logic [IDX_W-1:0]   idx,
  output logic [ENT_W-1:0]   addr
);
  localparam int PAD_W = ENT_W - IDX_W;

  // Entry = table page base + 4 * index (index never leaves the page).
  always_comb begin
    addr = {tbl_frame, {PAGE_SHIFT{1'b0}}} + ({{PAD_W{1'b0}}, idx} << 2);
  end
endmodule

// File: rtl/walk_entry_check.sv
module walk_entry_check
  import walk_pkg::*;
#(
  parameter bit LEAF = 1'b0
) (
  input  logic [ENT_W-1:0]   entry,
  input  logic               is_write,
  output logic               ok,
  output logic [FRAME_W-1:0] frame,
  output logic [ATTR_W-1:0]  attr
);
  logic unused_rsv;
  assign unused_rsv = ^entry[PAGE_SHIFT-1:1];

  assign frame = entry[ENT_W-1:PAGE_SHIFT];
  assign attr  = entry[ATTR_LSB +: ATTR_W];

  generate
    if (LEAF) begin : g_leaf
      logic perm_ok;
      always_comb begin
        perm_ok = is_write ? entry[BIT_WR] : entry[BIT_RD];
        ok      = entry[BIT_VALID] && perm_ok;
      end
    end else begin : g_dir
      logic unused_dir_wr;
      assign unused_dir_wr = is_write;
      always_comb begin
        ok = entry[BIT_VALID];
      end
    end
  endgenerate
endmodule

// File: rtl/walk_fault_capture.sv
module walk_fault_capture #(
  parameter int VA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_page,
  input  logic            set_bus,
  input  logic            clear,
  input  logic [VA_W-1:0] va,
  input  logic            is_write,
  output logic            page_flag,
  output logic            bus_flag,
  output logic [VA_W-1:0] fault_va,
  output logic            fault_write
);
  logic            page_q, page_d;
  logic            bus_q, bus_d;
  logic [VA_W-1:0] va_q;
  logic            wr_q;
  logic            cap_en;

  always_comb begin
    page_d = page_q;
    bus_d  = bus_q;
    cap_en = set_page | set_bus;
    if (clear) begin
      page_d = 1'b0;
      bus_d  = 1'b0;
    end
    if (set_page) page_d = 1'b1;
    if (set_bus)  bus_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= 1'b0;
      bus_q  <= 1'b0;
      va_q   <= '0;
      wr_q   <= 1'b0;
    end else begin
      page_q <= page_d;
      bus_q  <= bus_d;
      if (cap_en) begin
        va_q <= va;
        wr_q <= is_write;
      end
    end
  end

  assign page_flag   = page_q;
  assign bus_flag    = bus_q;
  assign fault_va    = va_q;
  assign fault_write = wr_q;

  p_kind_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(page_q && bus_q));

  p_capture_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (page_q || bus_q) && !clear |=> $stable(va_q) && $stable(wr_q));
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import walk_pkg::*;
#(
  parameter int L1_IDX_W = 10,
  parameter int L2_IDX_W = 10,
  localparam int VA_W = L1_IDX_W + L2_IDX_W + PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ENT_W-1:0]  dir_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic              req_write,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ENT_W-1:0]  mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ENT_W-1:0]  mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              rsp_valid,
  output logic [ENT_W-1:0]  rsp_pa,
  output logic [ATTR_W-1:0] rsp_attr,
  output logic              fault_page,
  output logic              fault_bus,
  output logic [VA_W-1:0]   fault_va,
  output logic              fault_write,
  input  logic              fault_done
);
  walk_state_e state_q, state_d;

  logic [VA_W-1:0]    va_q;
  logic               wr_q;
  logic [FRAME_W-1:0] base_q;
  logic [FRAME_W-1:0] tbl_q;
  logic               rsp_valid_q;
  logic [ENT_W-1:0]   rsp_pa_q;
  logic [ATTR_W-1:0]  rsp_attr_q;

  logic capture_req, tbl_en, rsp_fire, set_page, set_bus, fault_clear;

  logic [L1_IDX_W-1:0]   l1_idx;
  logic [L2_IDX_W-1:0]   l2_idx;
  logic [PAGE_SHIFT-1:0] page_off;
  logic [ENT_W-1:0]      l1_addr, l2_addr;

  logic               dir_ok, leaf_ok;
  logic [FRAME_W-1:0] dir_frame, leaf_frame;
  logic [ATTR_W-1:0]  unused_dir_attr, leaf_attr;
  logic               unused_base;

  assign unused_base = ^dir_base[PAGE_SHIFT-1:0];

  // Address split of the captured request
  assign l1_idx   = va_q[VA_W-1 -: L1_IDX_W];
  assign l2_idx   = va_q[PAGE_SHIFT +: L2_IDX_W];
  assign page_off = va_q[PAGE_SHIFT-1:0];

  walk_fetch_addr #(.IDX_W(L1_IDX_W)) u_l1_addr (
    .tbl_frame(base_q), .idx(l1_idx), .addr(l1_addr)
  );

  walk_fetch_addr #(.IDX_W(L2_IDX_W)) u_l2_addr (
    .tbl_frame(tbl_q), .idx(l2_idx), .addr(l2_addr)
  );

  walk_entry_check #(.LEAF(1'b0)) u_dir_chk (
    .entry(mem_rsp_data), .is_write(wr_q), .ok(dir_ok),
    .frame(dir_frame), .attr(unused_dir_attr)
  );

  walk_entry_check #(.LEAF(1'b1)) u_leaf_chk (
    .entry(mem_rsp_data), .is_write(wr_q), .ok(leaf_ok),
    .frame(leaf_frame), .attr(leaf_attr)
  );

  walk_fault_capture #(.VA_W(VA_W)) u_fault (
    .clk(clk), .rst_n(rst_n),
    .set_page(set_page), .set_bus(set_bus), .clear(fault_clear),
    .va(va_q), .is_write(wr_q),
    .page_flag(fault_page), .bus_flag(fault_bus),
    .fault_va(fault_va), .fault_write(fault_write)
  );

  // Next-state logic
  always_comb begin
    state_d     = state_q;
    capture_req = 1'b0;
    tbl_en      = 1'b0;
    rsp_fire    = 1'b0;
    set_page    = 1'b0;
    set_bus     = 1'b0;
    fault_clear = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          capture_req = 1'b1;
          state_d     = ST_L1_REQ;
        end
      end
      ST_L1_REQ: begin
        if (mem_req_ready) state_d = ST_L1_WAIT;
      end
      ST_L1_WAIT: begin
        if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            set_bus = 1'b1;
            state_d = ST_FAULT;
          end else if (!dir_ok) begin
            set_page = 1'b1;
            state_d  = ST_FAULT;
          end else begin
            tbl_en  = 1'b1;
            state_d = ST_L2_REQ;
          end
        end
      end
      ST_L2_REQ: begin
        if (mem_req_ready) state_d = ST_L2_WAIT;
      end
      ST_L2_WAIT: begin
        if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            set_bus = 1'b1;
            state_d = ST_FAULT;
          end else if (!leaf_ok) begin
            set_page = 1'b1;
            state_d  = ST_FAULT;
          end else begin
            rsp_fire = 1'b1;
            state_d  = ST_IDLE;
          end
        end
      end
      ST_FAULT: begin
        if (fault_done) begin
          fault_clear = 1'b1;
          state_d     = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      va_q        <= '0;
      wr_q        <= 1'b0;
      base_q      <= '0;
      tbl_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_pa_q    <= '0;
      rsp_attr_q  <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_fire;
      if (capture_req) begin
        va_q   <= req_va;
        wr_q   <= req_write;
        base_q <= dir_base[ENT_W-1:PAGE_SHIFT];
      end
      if (tbl_en) begin
        tbl_q <= dir_frame;
      end
      if (rsp_fire) begin
        rsp_pa_q   <= {leaf_frame, page_off};
        rsp_attr_q <= leaf_attr;
      end
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
  assign mem_req_addr  = (state_q == ST_L2_REQ) ? l2_addr : l1_addr;
  assign rsp_valid     = rsp_valid_q;
  assign rsp_pa        = rsp_pa_q;
  assign rsp_attr      = rsp_attr_q;

  p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_fault_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_page || fault_bus) |-> !req_ready && !mem_req_valid);

  p_fault_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_page || fault_bus) && fault_done |=> !fault_page && !fault_bus && req_ready);

  p_rsp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_no_rsp_on_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_page || fault_bus) |-> !rsp_valid);
endmodule

// File: tb/xlat_walker_test.sv
`timescale 1ns/1ps
module xlat_walker_test;
  localparam int L1W = 3;
  localparam int L2W = 3;
  localparam int VAW = L1W + L2W + 12;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [31:0]     dir_base;
  logic            req_valid, req_ready, req_write;
  logic [VAW-1:0]  req_va;
  logic            mem_req_valid, mem_req_ready;
  logic [31:0]     mem_req_addr;
  logic            mem_rsp_valid, mem_rsp_err;
  logic [31:0]     mem_rsp_data;
  logic            rsp_valid;
  logic [31:0]     rsp_pa;
  logic [5:0]      rsp_attr;
  logic            fault_page, fault_bus, fault_write, fault_done;
  logic [VAW-1:0]  fault_va;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  xlat_walker #(.L1_IDX_W(L1W), .L2_IDX_W(L2W)) uut (
    .clk(clk), .rst_n(rst_n), .dir_base(dir_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_write(req_write),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_attr(rsp_attr),
    .fault_page(fault_page), .fault_bus(fault_bus), .fault_va(fault_va),
    .fault_write(fault_write), .fault_done(fault_done)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // First-level entry: valid unless index 5; noise in ignored bits 11:1
  function automatic logic [31:0] dir_ent(input int i);
    logic [10:0] noise;
    logic [19:0] frame;
    noise = 11'(i * 677 + 1);
    frame = 20'(32'h100 + i);
    return {frame, noise, (i != 5)};
  endfunction

  // Second-level entry: invalid at index 7; grants and attributes vary
  function automatic logic [31:0] leaf_ent(input int i, input int j);
    int n;
    logic [19:0] frame;
    logic [5:0]  attr;
    n     = i * 8 + j;
    frame = 20'(32'hA0000 + n * 19);
    attr  = 6'(n) ^ 6'h2A;
    return {frame, 3'(n), attr, (n % 5 != 2), (n % 3 != 1), (j != 7)};
  endfunction

  task automatic clear_fault(input string tag);
    req_valid = 1'b1;
    req_va    = '0;
    for (int d = 0; d < 2; d++) begin
      @(negedge clk);
      chk({tag, " R10 blocked req_ready"}, 64'(req_ready), 64'd0);
      chk({tag, " R10 no mem request"}, 64'(mem_req_valid), 64'd0);
    end
    req_valid  = 1'b0;
    fault_done = 1'b1;
    @(negedge clk);
    fault_done = 1'b0;
    chk({tag, " R10 flags cleared"}, 64'({fault_page, fault_bus}), 64'd0);
    chk({tag, " R10 ready after done"}, 64'(req_ready), 64'd1);
  endtask

  task automatic fault_expect(input string tag, input bit bus, input logic [VAW-1:0] va, input bit wr);
    chk({tag, " R9 fault_bus"}, 64'(fault_bus), 64'(bus));
    chk({tag, " R6 fault_page"}, 64'(fault_page), 64'(!bus));
    chk({tag, " R8 fault_va"}, 64'(fault_va), 64'(va));
    chk({tag, " R8 fault_write"}, 64'(fault_write), 64'(wr));
    chk({tag, " R6 no rsp"}, 64'(rsp_valid), 64'd0);
    clear_fault(tag);
  endtask

  // err_at: 0 none, 1 bus error on first-level read, 2 on second-level read
  task automatic walk(input logic [VAW-1:0] va, input bit wr, input int rdly,
                      input int ldly, input int err_at);
    int i, j;
    logic [31:0] de, le, exp_a;
    bit perm_fail;
    i  = int'(va[VAW-1 -: L1W]);
    j  = int'(va[12 +: L2W]);
    de = dir_ent(i);
    le = leaf_ent(i, j);
    chk("R11 idle ready", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_va = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 busy not ready", 64'(req_ready), 64'd0);
    // first level (R1 split, R2 address)
    exp_a = {dir_base[31:12], 12'h000} + 32'(4 * i);
    for (int d = 0; d < rdly; d++) begin
      chk("R2 l1 req held", 64'({mem_req_valid, mem_req_addr}), 64'({1'b1, exp_a}));
      @(negedge clk);
    end
    chk("R2 l1 fetch addr", 64'({mem_req_valid, mem_req_addr}), 64'({1'b1, exp_a}));
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    for (int d = 0; d < ldly; d++) begin
      chk("R11 single outstanding", 64'(mem_req_valid), 64'd0);
      @(negedge clk);
    end
    mem_rsp_valid = 1'b1; mem_rsp_data = de; mem_rsp_err = (err_at == 1);
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
    if (err_at == 1) begin
      fault_expect("R9 l1 bus error", 1'b1, va, wr);
      return;
    end
    if (!de[0]) begin
      chk("R6 no second read", 64'(mem_req_valid), 64'd0);
      fault_expect("R6 l1 invalid", 1'b0, va, wr);
      return;
    end
    // second level (R3 address)
    exp_a = {de[31:12], 12'h000} + 32'(4 * j);
    for (int d = 0; d < ldly; d++) begin
      chk("R3 l2 req held", 64'({mem_req_valid, mem_req_addr}), 64'({1'b1, exp_a}));
      @(negedge clk);
    end
    chk("R3 l2 fetch addr", 64'({mem_req_valid, mem_req_addr}), 64'({1'b1, exp_a}));
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    for (int d = 0; d < rdly; d++) @(negedge clk);
    mem_rsp_valid = 1'b1; mem_rsp_data = le; mem_rsp_err = (err_at == 2);
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
    perm_fail = wr ? !le[2] : !le[1];
    if (err_at == 2) begin
      fault_expect("R9 l2 bus error", 1'b1, va, wr);
    end else if (!le[0]) begin
      fault_expect("R6 l2 invalid", 1'b0, va, wr);
    end else if (perm_fail) begin
      fault_expect("R7 permission", 1'b0, va, wr);
    end else begin
      chk("R4 rsp_valid", 64'(rsp_valid), 64'd1);
      chk("R4 rsp_pa", 64'(rsp_pa), 64'({le[31:12], va[11:0]}));
      chk("R5 rsp_attr", 64'(rsp_attr), 64'(le[8:3]));
      chk("R6 no fault on success", 64'({fault_page, fault_bus}), 64'd0);
      @(negedge clk);
      chk("R4 rsp one cycle", 64'(rsp_valid), 64'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; dir_base = 32'h0004_0000;
    req_valid = 1'b0; req_va = '0; req_write = 1'b0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0; mem_rsp_err = 1'b0;
    fault_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset ready", 64'(req_ready), 64'd1);
    chk("R11 reset no mem req", 64'(mem_req_valid), 64'd0);
    chk("R4 reset no rsp", 64'(rsp_valid), 64'd0);
    chk("R10 reset no fault", 64'({fault_page, fault_bus}), 64'd0);

    // Sweep: all pages, both directions (R1..R8)
    for (int n = 0; n < 64; n++) begin
      for (int w = 0; w < 2; w++) begin
        logic [11:0] off;
        dir_base = (n % 2 == 1) ? 32'h0004_0ABC : 32'h0004_0000;
        off = (n == 63) ? 12'hFFF : 12'(n * 37 + w * 1000);
        walk({3'(n / 8), 3'(n % 8), off}, w[0], (n + w) % 3, (2 * n + w) % 3, 0);
      end
    end

    // Bus errors (R9), including one on an invalid first-level entry
    dir_base = 32'h0004_0000;
    walk({3'd1, 3'd0, 12'h123}, 1'b0, 1, 1, 1);
    walk({3'd2, 3'd3, 12'h456}, 1'b1, 0, 0, 2);
    walk({3'd5, 3'd1, 12'h789}, 1'b1, 0, 2, 1);

    // Acknowledge with nothing pending has no effect (R10)
    fault_done = 1'b1;
    @(negedge clk);
    fault_done = 1'b0;
    @(negedge clk);
    chk("R10 stray done flags", 64'({fault_page, fault_bus}), 64'd0);
    chk("R10 stray done ready", 64'(req_ready), 64'd1);
    chk("R10 stray done rsp", 64'(rsp_valid), 64'd0);
    walk({3'd0, 3'd0, 12'hABC}, 1'b0, 0, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule